// File: doc/BRIEF.md
# First-Error Capture and Interrupt Unit

This unit sits beside a bus interface and watches eight error event lines. When the first error arrives it records the transaction address, the 64 data bits, the 8 data parity bits and, for an address parity error, the 4 address parity bits. It also records a selector that names which event was captured. After that the captured values stay frozen, so a later error cannot hide the original fault. They unfreeze only when software reads the captured low address word.

Each event also sets a sticky cause bit, whether or not capture is frozen. Software clears a cause bit by writing zero to it. A mask register chooses which cause bits raise the interrupt line.

The register map uses a 3-bit word index:
- 0: captured address
- 1: address parity, in bits [7:4]
- 2: data bits [31:0]
- 3: data bits [63:32]
- 4: data parity, in bits [7:0]
- 5: causes in bits [7:0] and the selector in bits [31:27]
- 6: mask, in bits [7:0]
- 7: reads as zero

Top module: `errcap_top`

## Requirements
- R1: After reset every register index reads zero and irq_o is low.
- R2: When capture is free and any event line is high at a clock edge, that edge stores the address in index 0, data bits [31:0] in index 2, data bits [63:32] in index 3 and the data parity in index 4 bits [7:0]. Reads are combinational from the stored state.
- R3: The selector in index 5 bits [31:27] names the captured event by its line number. The line order is: 0 out of range, 1 address parity, 2 transfer type violation, 3 protected access, 4 write protect, 5 cache protect, 6 write data parity, 7 read data parity. When several lines are high in the same cycle, the lowest number is captured. The selector never exceeds 7.
- R4: Once a capture has happened, later events leave indices 0 to 5 (selector field) unchanged. A cycle with reg_rd_i high and index 0 frees capture from the next cycle on. An event in that same read cycle is not captured.
- R5: Index 1 bits [7:4] hold the address parity only when the captured event is line 1; otherwise those bits are zero.
- R6: Every event sets its cause bit in index 5 bits [7:0], even while capture is frozen. Cause bits stay set until cleared.
- R7: A write to index 5 clears each cause bit whose write data bit is 0. Bits written with 1 are unchanged. An event in the same cycle sets its bit anyway. The selector bits of the write are ignored.
- R8: A write to index 6 loads the mask from bits [7:0]. Reading index 6 returns the mask.
- R9: irq_o is high exactly when some cause bit and the matching mask bit are both 1. It follows the registers one clock edge after the event or write.
- R10: Writes to indices 0 to 4 and 7 have no effect. Reserved bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 8 | Error event lines, one per cause |
| err_addr_i | input | 32 | Address of the failing transaction |
| err_data_i | input | 64 | Data of the failing transaction |
| err_dpar_i | input | 8 | Data parity of the failing transaction |
| err_apar_i | input | 4 | Address parity of the failing transaction |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The capture lock decides whether reads show stale or fresh data. If the lock state is wrong, the next read of the captured words after a second error shows the later address or a wrong selector instead of the first one. A bad cause or mask bit shows on irq_o one edge after the event or write that exposes it. It also shows in the very next read of index 5 or 6. Random event streams mixed with random reads, unlock reads and clear writes make these mismatches appear within a few cycles of their cause.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int NCAUSE    = 8;
  localparam int SEL_W     = 5;
  localparam int IDX_W     = 3;
  localparam int APAR_EVT  = 1;
  localparam int APAR_LSB  = 4;

  localparam logic [IDX_W-1:0] IX_ADDR  = 3'd0;
  localparam logic [IDX_W-1:0] IX_APAR  = 3'd1;
  localparam logic [IDX_W-1:0] IX_DLO   = 3'd2;
  localparam logic [IDX_W-1:0] IX_DHI   = 3'd3;
  localparam logic [IDX_W-1:0] IX_DPAR  = 3'd4;
  localparam logic [IDX_W-1:0] IX_CAUSE = 3'd5;
  localparam logic [IDX_W-1:0] IX_MASK  = 3'd6;
endpackage

// File: rtl/errcap_prio.sv
module errcap_prio
  import errcap_pkg::*;
#(
  parameter int N = NCAUSE
) (
  input  logic [N-1:0]     vec_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             any_o
);
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) sel_o = SEL_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/errcap_latch.sv
module errcap_latch
  import errcap_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int DPW = 8,
  parameter int APW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_any_i,
  input  logic [SEL_W-1:0] evt_sel_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [DPW-1:0]   dpar_i,
  input  logic [APW-1:0]   apar_i,
  input  logic             unlock_i,
  output logic             lock_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    data_o,
  output logic [DPW-1:0]   dpar_o,
  output logic [APW-1:0]   apar_o,
  output logic [SEL_W-1:0] sel_o
);
  logic take;
  assign take = evt_any_i && !lock_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      dpar_o <= '0;
      apar_o <= '0;
      sel_o  <= '0;
    end else if (take) begin
      lock_o <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
      dpar_o <= dpar_i;
      apar_o <= (evt_sel_i == SEL_W'(APAR_EVT)) ? apar_i : '0;
      sel_o  <= evt_sel_i;
    end else if (unlock_i) begin
      lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/errcap_cause.sv
module errcap_cause
  import errcap_pkg::*;
#(
  parameter int N = NCAUSE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_keep_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] cause_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] keep;
  assign keep = clr_we_i ? clr_keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      mask_o  <= '0;
    end else begin
      cause_o <= (cause_o & keep) | evt_i;
      if (mask_we_i) mask_o <= mask_wdata_i;
    end
  end

  assign irq_o = |(cause_o & mask_o);
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DPW   = 8,
  parameter int APW   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCAUSE-1:0]    err_evt_i,
  input  logic [REG_W-1:0]     err_addr_i,
  input  logic [2*REG_W-1:0]   err_data_i,
  input  logic [DPW-1:0]       err_dpar_i,
  input  logic [APW-1:0]       err_apar_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [IDX_W-1:0]     reg_idx_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o
);
  localparam int DW = 2 * REG_W;

  logic [SEL_W-1:0]  evt_sel;
  logic              evt_any;
  logic              lock_q;
  logic              unlock;
  logic              cause_we;
  logic              mask_we;
  logic [REG_W-1:0]  cap_addr;
  logic [DW-1:0]     cap_data;
  logic [DPW-1:0]    cap_dpar;
  logic [APW-1:0]    cap_apar;
  logic [SEL_W-1:0]  sel_q;
  logic [NCAUSE-1:0] cause_q;
  logic [NCAUSE-1:0] mask_q;

  assign unlock   = reg_rd_i && (reg_idx_i == IX_ADDR);
  assign cause_we = reg_wr_i && (reg_idx_i == IX_CAUSE);
  assign mask_we  = reg_wr_i && (reg_idx_i == IX_MASK);

  errcap_prio #(.N(NCAUSE)) u_prio (
    .vec_i (err_evt_i),
    .sel_o (evt_sel),
    .any_o (evt_any)
  );

  errcap_latch #(.AW(REG_W), .DW(DW), .DPW(DPW), .APW(APW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_any_i (evt_any),
    .evt_sel_i (evt_sel),
    .addr_i    (err_addr_i),
    .data_i    (err_data_i),
    .dpar_i    (err_dpar_i),
    .apar_i    (err_apar_i),
    .unlock_i  (unlock),
    .lock_o    (lock_q),
    .addr_o    (cap_addr),
    .data_o    (cap_data),
    .dpar_o    (cap_dpar),
    .apar_o    (cap_apar),
    .sel_o     (sel_q)
  );

  errcap_cause #(.N(NCAUSE)) u_cause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (err_evt_i),
    .clr_we_i     (cause_we),
    .clr_keep_i   (reg_wdata_i[NCAUSE-1:0]),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i[NCAUSE-1:0]),
    .cause_o      (cause_q),
    .mask_o       (mask_q),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      IX_ADDR:  reg_rdata_o = cap_addr;
      IX_APAR:  reg_rdata_o[APAR_LSB +: APW] = cap_apar;
      IX_DLO:   reg_rdata_o = cap_data[REG_W-1:0];
      IX_DHI:   reg_rdata_o = cap_data[DW-1:REG_W];
      IX_DPAR:  reg_rdata_o[DPW-1:0] = cap_dpar;
      IX_CAUSE: begin
        reg_rdata_o[NCAUSE-1:0]          = cause_q;
        reg_rdata_o[REG_W-1 -: SEL_W]    = sel_q;
      end
      IX_MASK:  reg_rdata_o[NCAUSE-1:0] = mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCAUSE-1:0] evt_i,
  input logic [NCAUSE-1:0] cause_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic              lock_q,
  input logic              unlock,
  input logic              cause_we,
  input logic              mask_we,
  input logic [REG_W-1:0]  cap_addr,
  input logic [REG_W-1:0]  wdata,
  input logic [SEL_W-1:0]  sel_q,
  input logic              irq_o
);
  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((evt_i & mask_q) != '0) && !mask_we) |=> irq_o);

  // R6
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  // R6
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R7
  write_one_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we |=> ((cause_q & $past(cause_q & wdata[NCAUSE-1:0]))
                  == $past(cause_q & wdata[NCAUSE-1:0])));

  // R4
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !unlock) |=> (lock_q && $stable(cap_addr) && $stable(sel_q)));

  // R2
  capture_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && (evt_i != '0)) |=> lock_q);

  // R3
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q < SEL_W'(NCAUSE));
endmodule

bind errcap_top errcap_chk #(.REG_W(REG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (err_evt_i),
  .cause_q  (cause_q),
  .mask_q   (mask_q),
  .lock_q   (lock_q),
  .unlock   (unlock),
  .cause_we (cause_we),
  .mask_we  (mask_we),
  .cap_addr (cap_addr),
  .wdata    (reg_wdata_i),
  .sel_q    (sel_q),
  .irq_o    (irq_o)
);

// File: tb/errcap_top_test.sv
module errcap_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic [31:0] addr = '0;
  logic [63:0] data = '0;
  logic [7:0]  dpar = '0;
  logic [3:0]  apar = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_addr = '0;
  logic [63:0] m_data = '0;
  logic [7:0]  m_dpar = '0;
  logic [3:0]  m_apar = '0;
  logic [4:0]  m_sel = '0;
  logic        m_lock = 1'b0;
  logic [7:0]  m_cause = '0;
  logic [7:0]  m_mask = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  errcap_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .err_evt_i   (evt),
    .err_addr_i  (addr),
    .err_data_i  (data),
    .err_dpar_i  (dpar),
    .err_apar_i  (apar),
    .reg_rd_i    (rd),
    .reg_wr_i    (wr),
    .reg_idx_i   (idx),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [31:0] model_read(input logic [2:0] i);
    case (i)
      3'd0: return m_addr;
      3'd1: return {24'd0, m_apar, 4'd0};
      3'd2: return m_data[31:0];
      3'd3: return m_data[63:32];
      3'd4: return {24'd0, m_dpar};
      3'd5: return {m_sel, 19'd0, m_cause};
      3'd6: return {24'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [4:0] lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic string tag_for(input logic [2:0] i);
    case (i)
      3'd1: return "R5";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic [31:0] a, input logic [63:0] d,
                      input logic [7:0] dp, input logic [3:0] ap, input logic w,
                      input logic r, input logic [2:0] ix, input logic [31:0] wd,
                      input string tag);
    @(negedge clk);
    evt = e; addr = a; data = d; dpar = dp; apar = ap;
    wr = w; rd = r; idx = ix; wdata = wd;
    #1;
    if (r) check((tag == "") ? tag_for(ix) : tag, rdata, model_read(ix));
    check("R9", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
    @(posedge clk);
    if (!m_lock && e != 8'd0) begin
      m_lock = 1'b1;
      m_addr = a; m_data = d; m_dpar = dp;
      m_sel  = lowest(e);
      m_apar = (m_sel == 5'd1) ? ap : 4'd0;
    end else if (r && ix == 3'd0) begin
      m_lock = 1'b0;
    end
    if (w && ix == 3'd5) m_cause = m_cause & wd[7:0];
    m_cause = m_cause | e;
    if (w && ix == 3'd6) m_mask = wd[7:0];
  endtask

  task automatic rd_reg(input logic [2:0] ix, input string tag);
    step(8'd0, 32'd0, 64'd0, 8'd0, 4'd0, 1'b0, 1'b1, ix, 32'd0, tag);
  endtask

  task automatic wr_reg(input logic [2:0] ix, input logic [31:0] wd);
    step(8'd0, 32'd0, 64'd0, 8'd0, 4'd0, 1'b1, 1'b0, ix, wd, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) rd_reg(3'(i), "R1");
    check("R1", {31'd0, irq}, 32'd0);

    // R8 mask and R3 priority among simultaneous events
    wr_reg(3'd6, 32'hffff_ff0c);
    step(8'b0110_1100, 32'hdead_0010, 64'h1111_2222_3333_4444, 8'h5a, 4'hf,
         1'b0, 1'b0, 3'd0, 32'd0, "");
    rd_reg(3'd5, "R3");
    rd_reg(3'd1, "R5");
    // R4 later events are not captured
    step(8'b0000_0010, 32'hbeef_0000, 64'h9, 8'h1, 4'h3, 1'b0, 1'b0, 3'd0, 32'd0, "");
    rd_reg(3'd2, "R4");
    rd_reg(3'd5, "R6");
    // R10 writes to capture words ignored
    wr_reg(3'd0, 32'hffff_ffff);
    wr_reg(3'd4, 32'hffff_ffff);
    rd_reg(3'd4, "R10");
    // R4 unlock read with a concurrent event: not captured
    step(8'b1000_0000, 32'h0bad_0bad, 64'h7, 8'h7, 4'h7, 1'b0, 1'b1, 3'd0, 32'd0, "R4");
    rd_reg(3'd0, "R4");
    // R5 address parity captured when event 1 is first
    step(8'b0000_0010, 32'h0000_1000, 64'h0, 8'h0, 4'ha, 1'b0, 1'b0, 3'd0, 32'd0, "");
    rd_reg(3'd1, "R5");
    // R7 write 0 clears, 1 keeps, concurrent event wins
    step(8'b0000_0001, 32'd0, 64'd0, 8'd0, 4'd0, 1'b1, 1'b0, 3'd5, 32'hf800_0010, "");
    rd_reg(3'd5, "R7");
    wr_reg(3'd5, 32'd0);
    rd_reg(3'd5, "R7");
    rd_reg(3'd0, "R4");

    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] e;
      logic [2:0] ix;
      logic w, r;
      e  = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      ix = 3'($urandom);
      w  = ($urandom % 4 == 0);
      r  = !w && ($urandom % 2 == 0);
      step(e, $urandom, {$urandom, $urandom}, 8'($urandom), 4'($urandom),
           w, r, ix, ($urandom % 2 == 0) ? $urandom : 32'($urandom) & 32'h0000_00ff, "");
    end
    for (int i = 0; i < 8; i++) rd_reg(3'(i), "");
    finish_run();
  end
endmodule